// File: doc/BRIEF.md
# Multi-Cycle Lifting Column Wavelet Engine

This block performs the vertical (column) pass of a line-based 2-D (9,7) wavelet transform using lifting. Each accepted cycle brings one pair of vertically adjacent samples of one image column: an even-row sample and an odd-row sample. Each accepted cycle also produces one low-pass and one high-pass coefficient. All lifting arithmetic runs in one shared combinational processing element.

The lifting pass carries four intermediate values per column from one row pair to the next. These values are kept in a single-port line memory with one entry per image column. The parameter `N` (2 or 4) sets how many consecutive row pairs of the same column are processed back to back. During those cycles the four values live in local registers. The memory is therefore read once and written once per `N` accepted cycles, and never both in the same cycle.

The read for the next column is issued in the last cycle of the current column's group. The write of the finished column is deferred by one cycle. This keeps the single port free of conflicts and leaves no bubble in the stream. Input stalls are supported through `valid_i`.

Top module: `wlt_col_engine`

## Requirements
- R1: While `rst_ni` is low and after its release with no accepted input, `valid_o` is 0 and `low_o`, `high_o` are 0.
- R2: `valid_o` is 1 in exactly the cycle after each cycle with `valid_i` = 1, and `low_o`/`high_o` in that cycle belong to the pair accepted one cycle earlier.
- R3: Arithmetic is bit exact to this definition. Samples are sign-extended to `SW` bits. Constants a=-1.586134, b=-0.052980, c=0.882911, d=0.443507, K=1.230174 and 1/K=0.812893 are rounded to nearest with `CF` fractional bits. A product m(v,k) is (v*k + 2^(CF-1)) >>> CF, truncated to `SW` bits, and every sum wraps to `SW` bits. With per-column state p0..p3 and pair (e,o), the stages are computed in order:
  - u1 = p0+m(e,a)
  - u2 = p1+m(u1,b)
  - u3 = p2+m(u2,c)
  - u4 = p3+m(u3,d)
  - new state: p0 = o+m(e,a), p1 = e+m(u1,b), p2 = u1+m(u2,c), p3 = u2+m(u3,d)
  - outputs: `low_o` = m(u4,K), `high_o` = m(u3,1/K)
- R4: Accepted pairs are assigned to columns in groups of `N`: column 0 for `N` pairs, then column 1, and so on up to `COLS`-1, then back to column 0. The first group of every column after reset starts from an all-zero state.
- R5: The line memory never sees a read and a write in the same cycle. Its accesses alternate read, write, read, write, starting with a read.
- R6: A read is issued in the last accepted cycle of each column group. Once one group has completed, a write occurs in the first accepted cycle of every following group, which means exactly every `N` accepted cycles.
- R7: A write goes to the column whose group just ended, which is the column one below the most recently read address, modulo `COLS`.
- R8: In a cycle with `valid_i` = 0 nothing advances: `low_o` and `high_o` hold their values and the next accepted pair continues the same schedule and state.
- R9: With `N` = 4, the outputs obey R3 and R4 exactly as with `N` = 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pair present this cycle |
| even_i | input | DW | Even-row sample, signed |
| odd_i | input | DW | Odd-row sample, signed |
| valid_o | output | 1 | Output coefficients present |
| low_o | output | SW | Low-pass coefficient, signed |
| high_o | output | SW | High-pass coefficient, signed |

## Verification
The assertions check the memory schedule on every cycle:
- the single-port rule and the read/write alternation;
- the spacing of writes every `N` accepted cycles;
- the write address relative to the last read;
- the one-cycle output lag;
- output hold during stalls.

Only the bench scenarios can show that the state carried through local registers and memory yields coefficients identical to a conventional model. That model reads and rewrites every column's state on every pair, for both `N` = 2 and `N` = 4. The scenarios include zero, random, stalled, impulse and extreme-value streams, and the comparison also covers zero state on first visit.

// File: rtl/wlt_pkg.sv
package wlt_pkg;
  parameter real LIFT_A = -1.586134;
  parameter real LIFT_B = -0.052980;
  parameter real LIFT_C = 0.882911;
  parameter real LIFT_D = 0.443507;
  parameter real GAIN_LO = 1.230174;
  parameter real GAIN_HI = 0.812893;

  // round-to-nearest fixed point conversion of a constant
  function automatic int fix_coef(real v, int fb);
    real s;
    s = v * (2.0 ** fb);
    if (s < 0.0) return $rtoi(s - 0.5);
    return $rtoi(s + 0.5);
  endfunction
endpackage

// File: rtl/wlt_scale.sv
module wlt_scale #(
  parameter int SW   = 16,
  parameter int CF   = 12,
  parameter int CW   = 14,
  parameter int COEF = 0
) (
  input  logic signed [SW-1:0] a_i,
  output logic signed [SW-1:0] y_o
);
  localparam int PW = SW + CW;
  localparam logic signed [PW-1:0] C_X = PW'(COEF);
  localparam logic signed [PW-1:0] RND = PW'(1) <<< (CF - 1);

  logic signed [PW-1:0] a_x, prod, rnd;

  assign a_x  = PW'(a_i);
  assign prod = a_x * C_X;
  assign rnd  = prod + RND;
  assign y_o  = rnd[CF+SW-1:CF];
endmodule

// File: rtl/wlt_lift_pe.sv
module wlt_lift_pe #(
  parameter int DW = 10,
  parameter int SW = 16,
  parameter int CF = 12,
  parameter int CW = 14
) (
  input  logic signed [DW-1:0]  even_i,
  input  logic signed [DW-1:0]  odd_i,
  input  logic [3:0][SW-1:0]    st_i,
  output logic [3:0][SW-1:0]    st_o,
  output logic signed [SW-1:0]  low_o,
  output logic signed [SW-1:0]  high_o
);
  localparam int K_LO = wlt_pkg::fix_coef(wlt_pkg::GAIN_LO, CF);
  localparam int K_HI = wlt_pkg::fix_coef(wlt_pkg::GAIN_HI, CF);
  localparam int COEF [4] = '{wlt_pkg::fix_coef(wlt_pkg::LIFT_A, CF),
                              wlt_pkg::fix_coef(wlt_pkg::LIFT_B, CF),
                              wlt_pkg::fix_coef(wlt_pkg::LIFT_C, CF),
                              wlt_pkg::fix_coef(wlt_pkg::LIFT_D, CF)};

  // u[k]: stage k operand, b[k]: value merged into carried state
  logic signed [SW-1:0] u [5];
  logic signed [SW-1:0] b [4];
  logic signed [SW-1:0] m [4];

  assign u[0] = SW'(even_i);

  for (genvar k = 0; k < 4; k++) begin : g_stage
    if (k == 0) begin : g_b0
      assign b[k] = SW'(odd_i);
    end else begin : g_bk
      assign b[k] = u[k-1];
    end
    wlt_scale #(.SW(SW), .CF(CF), .CW(CW), .COEF(COEF[k])) u_mul (
      .a_i(u[k]), .y_o(m[k])
    );
    assign u[k+1]  = $signed(st_i[k]) + m[k];
    assign st_o[k] = b[k] + m[k];
  end

  wlt_scale #(.SW(SW), .CF(CF), .CW(CW), .COEF(K_LO)) u_klo (
    .a_i(u[4]), .y_o(low_o)
  );
  wlt_scale #(.SW(SW), .CF(CF), .CW(CW), .COEF(K_HI)) u_khi (
    .a_i(u[3]), .y_o(high_o)
  );
endmodule

// File: rtl/wlt_sp_ram.sv
module wlt_sp_ram #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 128,
  parameter int AW    = 7
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    else if (re_i) rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/wlt_sched.sv
module wlt_sched #(
  parameter int COLS = 128,
  parameter int N    = 2,
  parameter int AW   = 7,
  parameter int PW   = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  output logic          first_o,
  output logic          band0_o,
  output logic          we_o,
  output logic          re_o,
  output logic [AW-1:0] addr_o
);
  logic [PW-1:0] phase_q;
  logic [AW-1:0] col_q, col_nxt, col_prv;
  logic          band0_q, started_q, last;

  assign last    = phase_q == PW'(N - 1);
  assign first_o = phase_q == '0;
  assign band0_o = band0_q;
  assign col_nxt = (col_q == AW'(COLS - 1)) ? '0 : col_q + 1'b1;
  assign col_prv = (col_q == '0) ? AW'(COLS - 1) : col_q - 1'b1;

  // deferred write of the finished column, read-ahead of the next one
  assign we_o   = acc_i && first_o && started_q;
  assign re_o   = acc_i && last;
  assign addr_o = we_o ? col_prv : col_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= '0;
      col_q     <= '0;
      band0_q   <= 1'b1;
      started_q <= 1'b0;
    end else if (acc_i) begin
      if (last) begin
        phase_q   <= '0;
        col_q     <= col_nxt;
        started_q <= 1'b1;
        if (col_q == AW'(COLS - 1)) band0_q <= 1'b0;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wlt_col_engine.sv
module wlt_col_engine #(
  parameter int COLS = 128,
  parameter int N    = 2,
  parameter int DW   = 10,
  parameter int SW   = 16,
  parameter int CF   = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] even_i,
  input  logic signed [DW-1:0] odd_i,
  output logic                 valid_o,
  output logic signed [SW-1:0] low_o,
  output logic signed [SW-1:0] high_o
);
  localparam int CW = CF + 2;
  localparam int AW = $clog2(COLS);
  localparam int PW = $clog2(N);
  localparam int MW = 4 * SW;

  logic              sel_first, band0, ram_we, ram_re;
  logic [AW-1:0]     ram_addr;
  logic [MW-1:0]     ram_rdata;
  logic [3:0][SW-1:0] loc_q, st_cur, st_nxt, mem_st;
  logic signed [SW-1:0] low_c, high_c;

  wlt_sched #(.COLS(COLS), .N(N), .AW(AW), .PW(PW)) u_sched (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(valid_i),
    .first_o(sel_first), .band0_o(band0),
    .we_o(ram_we), .re_o(ram_re), .addr_o(ram_addr)
  );

  // local registers still hold the previous column's final state at group start
  wlt_sp_ram #(.WIDTH(MW), .DEPTH(COLS), .AW(AW)) u_ram (
    .clk_i(clk_i), .we_i(ram_we), .re_i(ram_re), .addr_i(ram_addr),
    .wdata_i(loc_q), .rdata_o(ram_rdata)
  );

  assign mem_st = ram_rdata;
  assign st_cur = !sel_first ? loc_q : (band0 ? '0 : mem_st);

  wlt_lift_pe #(.DW(DW), .SW(SW), .CF(CF), .CW(CW)) u_pe (
    .even_i(even_i), .odd_i(odd_i), .st_i(st_cur), .st_o(st_nxt),
    .low_o(low_c), .high_o(high_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loc_q   <= '0;
      valid_o <= 1'b0;
      low_o   <= '0;
      high_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        loc_q  <= st_nxt;
        low_o  <= low_c;
        high_o <= high_c;
      end
    end
  end
endmodule

// File: rtl/wlt_col_engine_chk.sv
module wlt_col_engine_chk #(
  parameter int N    = 2,
  parameter int COLS = 128,
  parameter int AW   = 7,
  parameter int SW   = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          valid_o,
  input logic [SW-1:0] low_o,
  input logic [SW-1:0] high_o,
  input logic          ram_we,
  input logic          ram_re,
  input logic [AW-1:0] ram_addr
);
  logic [7:0]    since_wr;
  logic          seen_wr, last_rd;
  logic [AW-1:0] rd_addr_q, exp_wr;

  assign exp_wr = (rd_addr_q == '0) ? AW'(COLS - 1) : rd_addr_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_wr  <= '0;
      seen_wr   <= 1'b0;
      last_rd   <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      if (ram_we) begin
        since_wr <= 8'd1;
        seen_wr  <= 1'b1;
        last_rd  <= 1'b0;
      end else if (valid_i) begin
        since_wr <= since_wr + 8'd1;
      end
      if (ram_re) begin
        last_rd   <= 1'b1;
        rd_addr_q <= ram_addr;
      end
    end
  end

  assert_single_port_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we && ram_re));
  assert_wr_after_rd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |-> last_rd);
  assert_rd_after_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_re |-> !last_rd);
  assert_wr_period_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we && seen_wr) |-> since_wr == 8'(N));
  assert_wr_due_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && seen_wr && since_wr == 8'(N)) |-> ram_we);
  assert_wr_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |-> ram_addr == exp_wr);
  assert_valid_lag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_lag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(low_o) && $stable(high_o)));
endmodule

bind wlt_col_engine wlt_col_engine_chk #(.N(N), .COLS(COLS), .AW(AW), .SW(SW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .valid_o(valid_o),
  .low_o(low_o), .high_o(high_o), .ram_we(ram_we), .ram_re(ram_re),
  .ram_addr(ram_addr)
);

// File: tb/wlt_col_engine_test.sv
module wlt_col_engine_test;
  localparam int COLS = 128;
  localparam int DW   = 10;
  localparam int SW   = 16;
  localparam int CF   = 12;

  logic clk = 1'b0, rst_ni = 1'b0, valid = 1'b0;
  logic signed [DW-1:0] ev = '0, od = '0;
  logic v2, v4;
  logic signed [SW-1:0] lo2, hi2, lo4, hi4;

  always #10 clk = ~clk;

  wlt_col_engine #(.COLS(COLS), .N(2), .DW(DW), .SW(SW), .CF(CF)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .even_i(ev), .odd_i(od),
    .valid_o(v2), .low_o(lo2), .high_o(hi2));
  wlt_col_engine #(.COLS(COLS), .N(4), .DW(DW), .SW(SW), .CF(CF)) uut4 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .even_i(ev), .odd_i(od),
    .valid_o(v4), .low_o(lo4), .high_o(hi4));

  int checks = 0, fails = 0;
  bit done = 1'b0, mon_en = 1'b0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // conventional model: every pair reads and rewrites its column state
  function automatic int wrapw(longint v);
    logic signed [SW-1:0] t;
    t = v[SW-1:0];
    return int'(t);
  endfunction
  function automatic int fixc(real v);
    real s;
    s = v * (2.0 ** CF);
    return (s < 0.0) ? $rtoi(s - 0.5) : $rtoi(s + 0.5);
  endfunction
  function automatic int rmul(int a, int c);
    longint p;
    p = longint'(a) * longint'(c) + (longint'(1) << (CF - 1));
    return wrapw(p >>> CF);
  endfunction

  int coef [4];
  int k_lo, k_hi;
  int st2 [COLS][4];
  int st4 [COLS][4];
  int c2 = 0, p2 = 0, c4 = 0, p4 = 0;
  int q2lo[$], q2hi[$], q4lo[$], q4hi[$];

  task automatic lift(inout int s[4], input int xe, input int xo, output int lo, output int hi);
    int u, b, m, w, d2v, s2v;
    u = xe; b = xo; d2v = 0; s2v = 0;
    for (int k = 0; k < 4; k++) begin
      m = rmul(u, coef[k]);
      w = wrapw(longint'(s[k]) + m);
      s[k] = wrapw(longint'(b) + m);
      b = u; u = w;
      if (k == 2) d2v = w;
      if (k == 3) s2v = w;
    end
    lo = rmul(s2v, k_lo);
    hi = rmul(d2v, k_hi);
  endtask

  task automatic send(bit v, int e, int o);
    int lo, hi;
    @(negedge clk);
    valid = v; ev = DW'(e); od = DW'(o);
    if (v) begin
      lift(st2[c2], int'(ev), int'(od), lo, hi);
      q2lo.push_back(lo); q2hi.push_back(hi);
      p2++; if (p2 == 2) begin p2 = 0; c2 = (c2 + 1) % COLS; end
      lift(st4[c4], int'(ev), int'(od), lo, hi);
      q4lo.push_back(lo); q4hi.push_back(hi);
      p4++; if (p4 == 4) begin p4 = 0; c4 = (c4 + 1) % COLS; end
    end
  endtask

  logic sent_q = 1'b0;
  always @(posedge clk) sent_q <= valid;

  int prev_lo2 = 0, prev_hi2 = 0, prev_lo4 = 0, prev_hi4 = 0;
  always @(negedge clk) begin
    if (mon_en) begin
      check(v2 == sent_q && v4 == sent_q, "R2 valid lag", int'(v2), int'(sent_q));
      if (v2) begin
        if (q2lo.size() == 0) check(1'b0, "R2 unexpected output", 1, 0);
        else begin
          int el, eh;
          el = q2lo.pop_front(); eh = q2hi.pop_front();
          check(int'(lo2) == el, "R3/R4 low N=2", int'(lo2), el);
          check(int'(hi2) == eh, "R3/R4 high N=2", int'(hi2), eh);
        end
      end else begin
        check(int'(lo2) == prev_lo2 && int'(hi2) == prev_hi2, "R8 hold N=2", int'(lo2), prev_lo2);
      end
      if (v4) begin
        if (q4lo.size() == 0) check(1'b0, "R2 unexpected output", 1, 0);
        else begin
          int el, eh;
          el = q4lo.pop_front(); eh = q4hi.pop_front();
          check(int'(lo4) == el, "R9 low N=4", int'(lo4), el);
          check(int'(hi4) == eh, "R9 high N=4", int'(hi4), eh);
        end
      end else begin
        check(int'(lo4) == prev_lo4 && int'(hi4) == prev_hi4, "R8 hold N=4", int'(lo4), prev_lo4);
      end
    end
    prev_lo2 = int'(lo2); prev_hi2 = int'(hi2);
    prev_lo4 = int'(lo4); prev_hi4 = int'(hi4);
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    coef[0] = fixc(-1.586134); coef[1] = fixc(-0.052980);
    coef[2] = fixc(0.882911);  coef[3] = fixc(0.443507);
    k_lo = fixc(1.230174);     k_hi = fixc(0.812893);
    for (int c = 0; c < COLS; c++)
      for (int k = 0; k < 4; k++) begin st2[c][k] = 0; st4[c][k] = 0; end

    repeat (3) @(negedge clk);
    // R1 during reset
    check(v2 == 1'b0 && v4 == 1'b0, "R1 valid in reset", int'(v2), 0);
    check(lo2 == '0 && hi2 == '0, "R1 data in reset", int'(lo2), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(v2 == 1'b0 && v4 == 1'b0, "R1 valid after reset", int'(v2), 0);
    check(lo4 == '0 && hi4 == '0, "R1 data after reset", int'(lo4), 0);
    mon_en = 1'b1;

    // R4 first visit: zero stream, zero state
    for (int i = 0; i < 256; i++) send(1'b1, 0, 0);
    // R3 continuous random
    for (int i = 0; i < 1024; i++) send(1'b1, $signed($urandom_range(1023)) - 512, $signed($urandom_range(1023)) - 512);
    // R8 random stalls
    for (int i = 0; i < 1200; i++) begin
      if ($urandom_range(3) == 0) send(1'b0, $urandom_range(1023), $urandom_range(1023));
      else send(1'b1, $signed($urandom_range(1023)) - 512, $signed($urandom_range(1023)) - 512);
    end
    // impulse
    send(1'b1, 400, -300);
    for (int i = 0; i < 600; i++) send(1'b1, 0, 0);
    // R3 extremes
    for (int i = 0; i < 512; i++) send(1'b1, (i % 2) ? 511 : -512, (i % 3) ? -512 : 511);
    // drain
    for (int i = 0; i < 4; i++) send(1'b0, 0, 0);
    @(negedge clk);
    check(q2lo.size() == 0 && q4lo.size() == 0, "R2 all outputs seen", q2lo.size() + q4lo.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule